// File: doc/BRIEF.md
# NAT Port Translation Engine

This block rewrites IPv4 TCP/UDP header tuples at the boundary between a private LAN and the public WAN side of a router. A request carries a source address and port, a destination address and port, and a direction bit. For outbound traffic from a host with a private address, the source endpoint is replaced by the router's single public address and a public port. The port comes from an existing table entry for that private endpoint, or else a new one is allocated and recorded. For inbound traffic, the destination endpoint is matched against the public side of the table and restored to the private host it belongs to. The remote endpoint is never changed, so the far host only ever sees the public address.

The translation table is small and searched in parallel for both directions. Free public ports are handed out by a rotating offset that begins at the configured base port and steps over any port an entry already holds. Each request runs alone and takes a fixed two clock cycles. Both the request side and the result side use a valid/ready handshake. A request that cannot be translated returns its tuple unchanged with the drop flag set.

Top module: `nat_xlate`

## Requirements
- R1: An outbound source address is private when its top byte is 10, its top 12 bits are 0xAC1 (172.16.0.0 to 172.31.255.255), or its top 16 bits are 0xC0A8 (192.168.x.x). An outbound request from any other source leaves with all four fields unchanged and the drop flag clear.
- R2: An outbound request from a private source with no table entry leaves with source address PUB_IP and a newly allocated public port. Its destination is unchanged, the drop flag is clear, and an entry pairing the private endpoint with that port is stored.
- R3: Public ports are allocated as PORT_BASE plus an offset. The first allocation after reset uses offset 0. Each later allocation starts at one past the previous offset, wraps modulo PORT_SPAN, and skips ports held by a stored entry, so no two entries ever share a public port.
- R4: An outbound request whose private source address and port match a stored entry reuses that entry's public port. It allocates nothing and creates no entry.
- R5: An inbound request (direction 1) whose destination is PUB_IP and a stored public port leaves with its destination replaced by that entry's private address and port. Its source is unchanged and the drop flag is clear.
- R6: An inbound request whose destination address is not PUB_IP, or whose destination port no entry holds, leaves with the drop flag set and its tuple unchanged.
- R7: An outbound private request that needs a new entry while all ENTRIES slots are in use is dropped. Its tuple is unchanged and no entry is created.
- R8: An outbound private request that needs a new entry while every port in the range PORT_BASE to PORT_BASE+PORT_SPAN-1 is held is dropped, and no entry is created.
- R9: A request accepted at a clock edge (in_valid and in_ready both high) presents its result with out_valid high after the second following edge. in_ready stays low while a request or result is pending. While out_ready is low, out_valid and all result fields stay unchanged.
- R10: After reset, out_valid is 0, in_ready is 1 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Engine can take a request |
| in_dir | input | 1 | 0 = LAN to WAN, 1 = WAN to LAN |
| in_src_ip | input | 32 | Source address |
| in_src_port | input | 16 | Source port |
| in_dst_ip | input | 32 | Destination address |
| in_dst_port | input | 16 | Destination port |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_src_ip | output | 32 | Rewritten source address |
| out_src_port | output | 16 | Rewritten source port |
| out_dst_ip | output | 32 | Rewritten destination address |
| out_dst_port | output | 16 | Rewritten destination port |
| out_drop | output | 1 | Request could not be translated |

## Verification
A corrupted table entry or a miscounted allocation offset shows up on the very next outbound request from a new host, as a wrong source port. It also shows on the next inbound probe of the affected port, as a wrong private endpoint or as a hit where a drop was due. A wrongly computed full or no-free-port condition shows as a drop that comes too early or too late, at the exact request where capacity runs out. The bench drives two sizes side by side against a model of the table. One size runs out of slots first and the other runs out of ports first, so each of those two limits is reached at a known request.

// File: rtl/nat_pkg.sv
package nat_pkg;
  typedef struct packed {
    logic [31:0] ip;
    logic [15:0] port;
  } endpt_t;

  typedef enum logic {
    DIR_OUT = 1'b0,
    DIR_IN  = 1'b1
  } dir_e;
endpackage

// File: rtl/nat_priv_class.sv
module nat_priv_class (
  input  logic [15:0] ip_hi,
  output logic        is_private
);
  logic in_ten, in_172, in_192;

  always_comb begin
    in_ten     = (ip_hi[15:8] == 8'd10);
    in_172     = (ip_hi[15:4] == 12'hAC1);
    in_192     = (ip_hi == 16'hC0A8);
    is_private = in_ten | in_172 | in_192;
  end
endmodule

// File: rtl/nat_table.sv
module nat_table #(
  parameter int ENTRIES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [31:0]              ob_ip,
  input  logic [15:0]              ob_port,
  input  logic [15:0]              ib_port,
  input  logic                     wr_en,
  input  logic [31:0]              wr_ip,
  input  logic [15:0]              wr_port,
  input  logic [15:0]              wr_pub,
  output logic                     ob_hit,
  output logic [15:0]              ob_pub,
  output logic                     ib_hit,
  output logic [31:0]              ib_ip,
  output logic [15:0]              ib_port_o,
  output logic                     full,
  output logic [ENTRIES-1:0]       used_v,
  output logic [ENTRIES-1:0][15:0] used_pub
);
  logic [ENTRIES-1:0]       ent_v, ent_v_d;
  logic [ENTRIES-1:0][31:0] ent_ip;
  logic [ENTRIES-1:0][15:0] ent_port;
  logic [ENTRIES-1:0][15:0] ent_pub;
  logic [ENTRIES-1:0]       ob_match, ib_match, slot_sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign ob_match[i] = ent_v[i] && (ent_ip[i] == ob_ip) && (ent_port[i] == ob_port);
    assign ib_match[i] = ent_v[i] && (ent_pub[i] == ib_port);
  end

  always_comb begin
    ob_pub    = '0;
    ib_ip     = '0;
    ib_port_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ob_match[i]) ob_pub = ob_pub | ent_pub[i];
      if (ib_match[i]) begin
        ib_ip     = ib_ip | ent_ip[i];
        ib_port_o = ib_port_o | ent_port[i];
      end
    end
    ob_hit = |ob_match;
    ib_hit = |ib_match;
  end

  // lowest empty slot
  always_comb begin
    slot_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!ent_v[i]) slot_sel = ENTRIES'(1) << i;
    end
    full    = &ent_v;
    ent_v_d = wr_en ? (ent_v | slot_sel) : ent_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_v <= '0;
    else        ent_v <= ent_v_d;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < ENTRIES; i++) begin
      if (wr_en && slot_sel[i]) begin
        ent_ip[i]   <= wr_ip;
        ent_port[i] <= wr_port;
        ent_pub[i]  <= wr_pub;
      end
    end
  end

  assign used_v   = ent_v;
  assign used_pub = ent_pub;

  // R4: reuse keeps every private endpoint in at most one entry
  p_priv_unique_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ob_match));
  // R3: allocator never hands out a port already held
  p_pub_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ib_match));
  // R7: no entry is created into a full table
  p_no_write_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
endmodule

// File: rtl/nat_port_alloc.sv
module nat_port_alloc #(
  parameter int          ENTRIES   = 16,
  parameter logic [15:0] PORT_BASE = 16'd5000,
  parameter int          PORT_SPAN = 1024
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ENTRIES-1:0]       used_v,
  input  logic [ENTRIES-1:0][15:0] used_pub,
  input  logic                     advance,
  output logic                     found,
  output logic [15:0]              port
);
  localparam int WIN  = (PORT_SPAN < ENTRIES + 1) ? PORT_SPAN : ENTRIES + 1;
  localparam int OFFW = (PORT_SPAN > 1) ? $clog2(PORT_SPAN) : 1;
  localparam logic [OFFW:0] SPAN_W = (OFFW+1)'(PORT_SPAN);

  logic [OFFW-1:0] ptr, ptr_d, sel_off;
  logic [WIN-1:0]  cand_busy;
  logic [WIN-1:0][OFFW-1:0] cand_off;
  logic [OFFW:0]   sel_inc;

  for (genvar k = 0; k < WIN; k++) begin : g_cand
    logic [OFFW:0] sum;
    logic [15:0]   cport;
    always_comb begin
      sum         = {1'b0, ptr} + (OFFW+1)'(k);
      cand_off[k] = (sum >= SPAN_W) ? OFFW'(sum - SPAN_W) : OFFW'(sum);
      cport       = PORT_BASE + 16'(cand_off[k]);
      cand_busy[k] = 1'b0;
      for (int e = 0; e < ENTRIES; e++) begin
        if (used_v[e] && (used_pub[e] == cport)) cand_busy[k] = 1'b1;
      end
    end
  end

  always_comb begin
    found   = 1'b0;
    sel_off = '0;
    for (int k = WIN - 1; k >= 0; k--) begin
      if (!cand_busy[k]) begin
        found   = 1'b1;
        sel_off = cand_off[k];
      end
    end
    port    = PORT_BASE + 16'(sel_off);
    sel_inc = {1'b0, sel_off} + 1'b1;
    ptr_d   = ptr;
    if (advance && found) ptr_d = (sel_inc == SPAN_W) ? '0 : OFFW'(sel_inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_d;
  end

  // R3: offset always inside the port range
  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, ptr} < SPAN_W);
endmodule

// File: rtl/nat_xlate.sv
module nat_xlate #(
  parameter logic [31:0] PUB_IP    = 32'hC633_6407,
  parameter int          ENTRIES   = 16,
  parameter logic [15:0] PORT_BASE = 16'd5000,
  parameter int          PORT_SPAN = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_dir,
  input  logic [31:0] in_src_ip,
  input  logic [15:0] in_src_port,
  input  logic [31:0] in_dst_ip,
  input  logic [15:0] in_dst_port,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_src_ip,
  output logic [15:0] out_src_port,
  output logic [31:0] out_dst_ip,
  output logic [15:0] out_dst_port,
  output logic        out_drop
);
  import nat_pkg::*;

  logic   req_v, req_v_d, out_v, out_v_d;
  dir_e   req_dir;
  endpt_t req_src, req_dst;
  endpt_t res_src, res_dst, o_src, o_dst;
  logic   res_drop, o_drop;
  logic   accept, priv;
  logic   ob_hit, ib_hit, full, found, wr_en, adv;
  logic [15:0] ob_pub, ib_port, alloc_port;
  logic [31:0] ib_ip;
  logic [ENTRIES-1:0]       used_v;
  logic [ENTRIES-1:0][15:0] used_pub;

  nat_priv_class u_class (
    .ip_hi      (req_src.ip[31:16]),
    .is_private (priv)
  );

  nat_table #(.ENTRIES(ENTRIES)) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .ob_ip     (req_src.ip),
    .ob_port   (req_src.port),
    .ib_port   (req_dst.port),
    .wr_en     (wr_en),
    .wr_ip     (req_src.ip),
    .wr_port   (req_src.port),
    .wr_pub    (alloc_port),
    .ob_hit    (ob_hit),
    .ob_pub    (ob_pub),
    .ib_hit    (ib_hit),
    .ib_ip     (ib_ip),
    .ib_port_o (ib_port),
    .full      (full),
    .used_v    (used_v),
    .used_pub  (used_pub)
  );

  nat_port_alloc #(
    .ENTRIES   (ENTRIES),
    .PORT_BASE (PORT_BASE),
    .PORT_SPAN (PORT_SPAN)
  ) u_alloc (
    .clk      (clk),
    .rst_n    (rst_n),
    .used_v   (used_v),
    .used_pub (used_pub),
    .advance  (adv),
    .found    (found),
    .port     (alloc_port)
  );

  // handshake next state
  always_comb begin
    in_ready = !req_v && !out_v;
    accept   = in_valid && in_ready;
    req_v_d  = accept ? 1'b1 : (req_v ? 1'b0 : req_v);
    out_v_d  = req_v ? 1'b1 : (out_ready ? 1'b0 : out_v);
  end

  // translation decision
  always_comb begin
    res_src  = req_src;
    res_dst  = req_dst;
    res_drop = 1'b0;
    wr_en    = 1'b0;
    adv      = 1'b0;
    if (req_dir == DIR_OUT) begin
      if (priv) begin
        if (ob_hit) begin
          res_src = '{ip: PUB_IP, port: ob_pub};
        end else if (!full && found) begin
          res_src = '{ip: PUB_IP, port: alloc_port};
          wr_en   = req_v;
          adv     = req_v;
        end else begin
          res_drop = 1'b1;
        end
      end
    end else begin
      if ((req_dst.ip == PUB_IP) && ib_hit) res_dst = '{ip: ib_ip, port: ib_port};
      else                                  res_drop = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_v <= 1'b0;
      out_v <= 1'b0;
    end else begin
      req_v <= req_v_d;
      out_v <= out_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      req_dir <= dir_e'(in_dir);
      req_src <= '{ip: in_src_ip, port: in_src_port};
      req_dst <= '{ip: in_dst_ip, port: in_dst_port};
    end
    if (req_v) begin
      o_src  <= res_src;
      o_dst  <= res_dst;
      o_drop <= res_drop;
    end
  end

  assign out_valid    = out_v;
  assign out_src_ip   = o_src.ip;
  assign out_src_port = o_src.port;
  assign out_dst_ip   = o_dst.ip;
  assign out_dst_port = o_dst.port;
  assign out_drop     = o_drop;

  // R9: result appears two edges after acceptance
  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> ##1 out_valid);
  // R9: stalled result holds
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid &&
      $stable({out_src_ip, out_src_port, out_dst_ip, out_dst_port, out_drop})));
endmodule

// File: tb/nat_xlate_test.sv
module nat_xlate_test;
  localparam logic [31:0] PUB = 32'hC633_6407;
  localparam int E0 = 4, S0 = 8, E1 = 8, S1 = 5;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_dir, out_ready;
  logic [31:0] in_src_ip, in_dst_ip;
  logic [15:0] in_src_port, in_dst_port;
  logic        rdy [2], ov [2], od [2];
  logic [31:0] osi [2], odi [2];
  logic [15:0] osp [2], odp [2];

  always #2.5 clk = ~clk;

  nat_xlate #(.PUB_IP(PUB), .ENTRIES(E0), .PORT_BASE(16'd5000), .PORT_SPAN(S0)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[0]), .in_dir(in_dir),
    .in_src_ip(in_src_ip), .in_src_port(in_src_port), .in_dst_ip(in_dst_ip),
    .in_dst_port(in_dst_port), .out_valid(ov[0]), .out_ready(out_ready),
    .out_src_ip(osi[0]), .out_src_port(osp[0]), .out_dst_ip(odi[0]),
    .out_dst_port(odp[0]), .out_drop(od[0]));

  nat_xlate #(.PUB_IP(PUB), .ENTRIES(E1), .PORT_BASE(16'd5000), .PORT_SPAN(S1)) uut_np (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy[1]), .in_dir(in_dir),
    .in_src_ip(in_src_ip), .in_src_port(in_src_port), .in_dst_ip(in_dst_ip),
    .in_dst_port(in_dst_port), .out_valid(ov[1]), .out_ready(out_ready),
    .out_src_ip(osi[1]), .out_src_port(osp[1]), .out_dst_ip(odi[1]),
    .out_dst_port(odp[1]), .out_drop(od[1]));

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  // reference model, one table per instance
  bit          m_v   [2][8];
  logic [31:0] m_ip  [2][8];
  logic [15:0] m_pt  [2][8];
  logic [15:0] m_pub [2][8];
  int          m_ptr [2];
  int          m_e   [2] = '{E0, E1};
  int          m_s   [2] = '{S0, S1};

  function automatic bit is_priv(logic [31:0] a);
    return (a[31:24] == 8'd10) || (a[31:20] == 12'hAC1) || (a[31:16] == 16'hC0A8);
  endfunction

  task automatic model(input int k, input logic d, input logic [31:0] si, input logic [15:0] sp,
                       input logic [31:0] di, input logic [15:0] dp,
                       output logic [31:0] esi, output logic [15:0] esp,
                       output logic [31:0] edi, output logic [15:0] edp,
                       output logic edrop, output string tag);
    int cnt, slot, off;
    bit hit, busy;
    esi = si; esp = sp; edi = di; edp = dp; edrop = 0;
    if (d == 1'b0) begin
      if (!is_priv(si)) begin tag = "R1"; return; end
      hit = 0;
      for (int i = 0; i < m_e[k]; i++)
        if (m_v[k][i] && m_ip[k][i] == si && m_pt[k][i] == sp) begin
          hit = 1; esi = PUB; esp = m_pub[k][i];
        end
      if (hit) begin tag = "R4"; return; end
      cnt = 0; slot = -1;
      for (int i = m_e[k] - 1; i >= 0; i--) begin
        if (m_v[k][i]) cnt++; else slot = i;
      end
      if (cnt == m_e[k]) begin edrop = 1; tag = "R7"; return; end
      off = -1;
      for (int j = m_s[k] - 1; j >= 0; j--) begin
        busy = 0;
        for (int i = 0; i < m_e[k]; i++)
          if (m_v[k][i] && m_pub[k][i] == 16'(5000 + (m_ptr[k] + j) % m_s[k])) busy = 1;
        if (!busy) off = (m_ptr[k] + j) % m_s[k];
      end
      if (off < 0) begin edrop = 1; tag = "R8"; return; end
      esi = PUB; esp = 16'(5000 + off);
      m_v[k][slot] = 1; m_ip[k][slot] = si; m_pt[k][slot] = sp; m_pub[k][slot] = esp;
      m_ptr[k] = (off + 1) % m_s[k];
      tag = "R2,R3";
    end else begin
      hit = 0;
      for (int i = 0; i < m_e[k]; i++)
        if (di == PUB && m_v[k][i] && m_pub[k][i] == dp) begin
          hit = 1; edi = m_ip[k][i]; edp = m_pt[k][i];
        end
      if (hit) tag = "R5";
      else begin edrop = 1; tag = "R6"; end
    end
  endtask

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // one request through both instances; outputs checked at negedge after the second edge
  task automatic xact(input logic d, input logic [31:0] si, input logic [15:0] sp,
                      input logic [31:0] di, input logic [15:0] dp, input bit stall);
    logic [31:0] esi [2], edi [2];
    logic [15:0] esp [2], edp [2];
    logic        edr [2];
    string       tg  [2];
    for (int k = 0; k < 2; k++)
      model(k, d, si, sp, di, dp, esi[k], esp[k], edi[k], edp[k], edr[k], tg[k]);
    @(negedge clk);
    chk("R9 in_ready idle", {126'd0, rdy[0], rdy[1]}, 128'd3);
    in_valid = 1; in_dir = d; in_src_ip = si; in_src_port = sp; in_dst_ip = di; in_dst_port = dp;
    if (stall) out_ready = 0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R9 no early result", {126'd0, ov[0], ov[1]}, 128'd0);
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk({tg[k], " result"}, {15'd0, ov[k], osi[k], osp[k], odi[k], odp[k], od[k]},
          {15'd0, 1'b1, esi[k], esp[k], edi[k], edp[k], edr[k]});
    end
    if (stall) begin
      repeat (3) @(negedge clk);
      for (int k = 0; k < 2; k++) begin
        chk("R9 stalled hold", {15'd0, ov[k], osi[k], osp[k], odi[k], odp[k], od[k]},
            {15'd0, 1'b1, esi[k], esp[k], edi[k], edp[k], edr[k]});
        chk("R9 in_ready low while held", {127'd0, rdy[k]}, 128'd0);
      end
      out_ready = 1;
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int oct [9] = '{9, 10, 11, 171, 172, 173, 191, 192, 193};
    int sec [9] = '{0, 15, 16, 31, 32, 167, 168, 169, 255};
    logic [31:0] rem = 32'hCB00_7109;
    for (int k = 0; k < 2; k++) begin
      m_ptr[k] = 0;
      for (int i = 0; i < 8; i++) m_v[k][i] = 0;
    end
    rst_n = 0; in_valid = 0; in_dir = 0; out_ready = 1;
    in_src_ip = '0; in_src_port = '0; in_dst_ip = '0; in_dst_port = '0;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++)
      chk("R10 reset state", {126'd0, ov[k], rdy[k]}, 128'd1);
    rst_n = 1;
    // inbound before anything exists: empty table drops
    xact(1, rem, 16'd443, PUB, 16'd5000, 0);
    // classification sweep across range edges; fills tables as privates arrive
    for (int a = 0; a < 9; a++)
      for (int b = 0; b < 9; b++)
        xact(0, {8'(oct[a]), 8'(sec[b]), 8'd1, 8'd2}, 16'(40000 + a * 9 + b), rem, 16'd80, 0);
    // near-exhaustive first byte sweep with second byte 168
    for (int a = 0; a < 256; a++)
      xact(0, {8'(a), 8'd168, 8'd7, 8'd7}, 16'd1234, rem, 16'd53, 0);
    // inbound probes across and beyond the port range
    for (int p = 4998; p < 5010; p++)
      xact(1, rem, 16'd80, PUB, 16'(p), 0);
    xact(1, rem, 16'd80, PUB ^ 32'h1, 16'd5000, 0);
    // reuse of the first private endpoint (10.0.1.2:40009)
    xact(0, 32'h0A00_0102, 16'd40009, 32'h0808_0808, 16'd443, 0);
    // stalled output with reuse traffic
    xact(0, 32'h0A00_0102, 16'd40009, rem, 16'd80, 1);
    xact(1, 32'h0808_0808, 16'd443, PUB, 16'd5001, 1);
    finish_run();
  end
endmodule